// File: doc/BRIEF.md
# Wake Event Status Register

This block is a 16-bit status and control word held inside a power management unit. After the processor core comes back from a low-power state, software reads the word to learn which events woke it or arrived while it slept. Four events are recorded: a general-purpose I/O interrupt, an interrupt from a removable card slot, a real-time clock alarm, and a low-battery condition seen during activation. Each of these is a sticky flag. It is set by a one-cycle event pulse and cleared only when software writes a 1 to it.

The same word also shows the live, synchronised level of a carrier-detect pin. It holds one read/write policy bit as well. That bit tells the reset controller whether a reset-switch event may leave the internal peripherals, and so the contents of the external SDRAM, untouched. The policy bit is also brought out on a dedicated output.

Access is over a simple synchronous register bus: select, address, write enable, write data and combinational read data. Two active-low reset sources, one from the real-time clock domain and one system reset, each clear the whole word. Either reset is asserted asynchronously and released in step with the clock.

Top module: `wake_status_reg`

## Requirements
- R1: After reset, with the carrier-detect pin low, the word reads 0x0000 and the policy output is 0.
- R2: A high pulse on an event input sets its flag at the next clock edge, and the flag then stays set. The flag positions are: low battery at bit 8, clock alarm at bit 9, card interrupt at bit 11, I/O interrupt at bit 12.
- R3: Writing 1 to a flag bit clears it. Writing 0 to it leaves it unchanged.
- R4: If an event pulse and a write of 1 hit the same flag in the same cycle, the flag ends up set.
- R5: Bit 10 shows the carrier-detect pin level (1 = high, inactive) two clock edges after the pin changes. Writes have no effect on this bit.
- R6: Bit 6 is a plain read/write policy bit (1 = peripherals are kept through a reset-switch event). Its value also drives the policy output.
- R7: Bits 15 to 13, bit 7 and bits 5 to 0 always read 0, and writes to them have no effect.
- R8: The word is reached only when select is high and the address equals the configured register address. Otherwise read data is 0 and writes change nothing.
- R9: Asserting either reset input on its own clears all flags and the policy bit.
- R10: Reading the word does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rtc_rst_n | input | 1 | Active-low reset from the real-time clock domain |
| sys_rst_n | input | 1 | Active-low system reset |
| bus_sel | input | 1 | Register bus select |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write enable, qualified by select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| evt_batt | input | 1 | Low-battery-at-activation event pulse |
| evt_rtc | input | 1 | Clock alarm event pulse |
| evt_card | input | 1 | Card interrupt event pulse |
| evt_gpio | input | 1 | I/O interrupt event pulse |
| cd_pin | input | 1 | Asynchronous carrier-detect pin |
| keep_periph | output | 1 | Policy bit sent to the reset controller |

## Verification
The bench uses the default parameters: an 8-bit address, register address 0xA0 and a two-stage synchroniser. The 8-bit address space is small enough to sweep every address for the decode and ignored-write checks. With four flags, every combination of prior flag state, same-cycle event pattern and clear mask can be tried: 4096 cases, each compared against an arithmetic expectation. The two-stage depth makes the carrier-detect latency a fixed two edges, so the bench checks that exact edge.

// File: rtl/wake_status_pkg.sv
package wake_status_pkg;
  localparam int REG_W    = 16;
  localparam int NUM_EVT  = 4;
  localparam int POS_CD   = 10;
  localparam int POS_KEEP = 6;
  localparam logic [REG_W-1:0] RSVD_MASK = 16'hE0BF;

  // event index -> bit position: 0 battery, 1 alarm, 2 card, 3 gpio
  function automatic int evt_pos(input int idx);
    case (idx)
      0:       evt_pos = 8;
      1:       evt_pos = 9;
      2:       evt_pos = 11;
      default: evt_pos = 12;
    endcase
  endfunction
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign q_o = sr_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      // R5: output edges follow the input two edges later
      assert_sync_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_o) |-> $past(d_i, 2));
      assert_sync_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q_o) |-> !$past(d_i, 2));
    end
  endgenerate
endmodule

// File: rtl/wake_flag.sv
module wake_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;
  logic q_d;
  logic en;

  always_comb begin
    en  = set_i | clr_i;
    q_d = set_i ? 1'b1 : 1'b0;  // set has priority over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_q <= 1'b0;
    else if (en) q_q <= q_d;
  end

  assign q_o = q_q;

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/wake_status_reg.sv
module wake_status_reg
  import wake_status_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 8'hA0,
  parameter int              SYNC_STAGES = 2,
  parameter int              RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rtc_rst_n,
  input  logic              sys_rst_n,
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              evt_batt,
  input  logic              evt_rtc,
  input  logic              evt_card,
  input  logic              evt_gpio,
  input  logic              cd_pin,
  output logic              keep_periph
);
  logic             arst_n;
  logic             rst_n;
  logic             hit;
  logic             wr_hit;
  logic [NUM_EVT-1:0] evt_v;
  logic [NUM_EVT-1:0] flag_v;
  logic             cd_s;
  logic             keep_q;
  logic             keep_d;
  logic [REG_W-1:0] word;
  logic             unused_wdata;

  assign arst_n = rtc_rst_n & sys_rst_n;

  // asynchronous assert, clocked release of the combined reset
  wake_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(arst_n), .d_i(1'b1), .q_o(rst_n)
  );

  wake_sync #(.STAGES(SYNC_STAGES)) u_cd_sync (
    .clk(clk), .rst_n(rst_n), .d_i(cd_pin), .q_o(cd_s)
  );

  always_comb begin
    hit    = bus_sel && (bus_addr == REG_ADDR);
    wr_hit = hit && bus_wr;
    evt_v  = {evt_gpio, evt_card, evt_rtc, evt_batt};
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_EVT; gi++) begin : g_flag
      wake_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(evt_v[gi]),
        .clr_i(wr_hit & bus_wdata[evt_pos(gi)]),
        .q_o  (flag_v[gi])
      );
    end
  endgenerate

  always_comb begin
    keep_d = bus_wdata[POS_KEEP];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      keep_q <= 1'b0;
    else if (wr_hit) keep_q <= keep_d;
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < NUM_EVT; i++) word[evt_pos(i)] = flag_v[i];
    word[POS_CD]   = cd_s;
    word[POS_KEEP] = keep_q;
    bus_rdata = hit ? word : '0;
  end

  assign keep_periph  = keep_q;
  assign unused_wdata = ^{bus_wdata[15:13], bus_wdata[10], bus_wdata[7], bus_wdata[5:0]};

  assert_policy_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (keep_periph == $past(bus_wdata[POS_KEEP])));
  assert_policy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(keep_periph));
  assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & RSVD_MASK) == '0);
  assert_decode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (bus_rdata == '0));
endmodule

// File: tb/wake_status_reg_tb.sv
module wake_status_reg_tb_top;
  localparam logic [7:0] RA = 8'hA0;

  logic        clk;
  logic        rtc_rst_n, sys_rst_n;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [3:0]  ev;
  logic        cd_pin;
  logic        keep_periph;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  wake_status_reg dut_i (
    .clk(clk), .rtc_rst_n(rtc_rst_n), .sys_rst_n(sys_rst_n),
    .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_batt(ev[0]), .evt_rtc(ev[1]), .evt_card(ev[2]), .evt_gpio(ev[3]),
    .cd_pin(cd_pin), .keep_periph(keep_periph)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [15:0] ex(input logic [3:0] m);
    logic [15:0] r = '0;
    r[8] = m[0]; r[9] = m[1]; r[11] = m[2]; r[12] = m[3];
    return r;
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(output logic [15:0] v);
    bus_sel = 1; bus_wr = 0; bus_addr = RA; #1;
    v = bus_rdata; bus_sel = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic pulse(input logic [3:0] m);
    ev = m; tick(); ev = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (all R) got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v, v2;
    rtc_rst_n = 0; sys_rst_n = 0; bus_sel = 0; bus_wr = 0;
    bus_addr = '0; bus_wdata = '0; ev = '0; cd_pin = 0;
    repeat (3) @(negedge clk);
    rtc_rst_n = 1; sys_rst_n = 1;
    repeat (3) tick();

    // R1 reset state
    rd(v); chk("R1 word", v, 16'h0000);
    chk("R1 keep", {15'b0, keep_periph}, 16'h0000);

    // R2 single events, sticky
    for (int i = 0; i < 4; i++) begin
      wr(RA, 16'h1B00);
      pulse(4'(1 << i));
      repeat (3) tick();
      rd(v); chk("R2 single", v, ex(4'(1 << i)));
    end
    // R10 repeated reads unchanged
    rd(v); tick(); rd(v2); chk("R10 reread", v2, v);
    // R3 write zero keeps, write one clears
    pulse(4'hF);
    wr(RA, 16'h0000); rd(v); chk("R3 write0", v, ex(4'hF));
    for (int i = 0; i < 4; i++) begin
      wr(RA, ex(4'(1 << i))); rd(v);
      chk("R3 clear one", v, ex(4'hF & ~((4'hF >> (3 - i)))) );
    end

    // R3/R4 exhaustive prior x event x clear
    for (int p = 0; p < 16; p++)
      for (int e = 0; e < 16; e++)
        for (int c = 0; c < 16; c++) begin
          wr(RA, 16'h1B00);
          pulse(4'(p));
          ev = 4'(e);
          wr(RA, ex(4'(c)));
          ev = '0;
          rd(v);
          chk("R4 set-vs-clear", v, ex((4'(p) & ~4'(c)) | 4'(e)));
        end

    // R5 carrier detect latency and read-only
    wr(RA, 16'h1B00);
    cd_pin = 1; tick(); rd(v); chk("R5 one edge", v, 16'h0000);
    tick(); rd(v); chk("R5 two edges", v, 16'h0400);
    wr(RA, 16'h0000); rd(v); chk("R5 write0 ro", v, 16'h0400);
    cd_pin = 0; tick(); rd(v); chk("R5 fall one edge", v, 16'h0400);
    tick(); rd(v); chk("R5 fall two edges", v, 16'h0000);
    wr(RA, 16'h0400); rd(v); chk("R5 write1 ro", v, 16'h0000);

    // R6 policy bit
    wr(RA, 16'h0040); rd(v); chk("R6 set read", v, 16'h0040);
    chk("R6 set out", {15'b0, keep_periph}, 16'h0001);
    wr(RA, 16'h0000); rd(v); chk("R6 clr read", v, 16'h0000);
    chk("R6 clr out", {15'b0, keep_periph}, 16'h0000);

    // R7 reserved bits
    wr(RA, 16'hE0BF); rd(v); chk("R7 rsvd write", v, 16'h0000);
    wr(RA, 16'hFFFF); rd(v); chk("R7 all ones", v, 16'h0040);

    // R8 address sweep
    pulse(4'hF);
    for (int a = 0; a < 256; a++) begin
      if (8'(a) != RA) begin
        wr(8'(a), 16'h1B00);
        bus_sel = 1; bus_addr = 8'(a); #1;
        chk("R8 other addr read", bus_rdata, 16'h0000);
        bus_sel = 0;
      end
    end
    rd(v); chk("R8 other addr write", v, ex(4'hF) | 16'h0040);
    bus_sel = 0; bus_addr = RA; #1; chk("R8 unselected", bus_rdata, 16'h0000);
    bus_wr = 1; bus_wdata = 16'h1B00; tick(); bus_wr = 0;
    rd(v); chk("R8 unselected write", v, ex(4'hF) | 16'h0040);

    // R9 each reset alone
    sys_rst_n = 0; #1; rd(v); chk("R9 sys reset", v, 16'h0000);
    chk("R9 sys keep", {15'b0, keep_periph}, 16'h0000);
    tick(); sys_rst_n = 1; repeat (3) tick();
    pulse(4'hF); wr(RA, 16'h0040);
    rtc_rst_n = 0; #1; rd(v); chk("R9 rtc reset", v, 16'h0000);
    chk("R9 rtc keep", {15'b0, keep_periph}, 16'h0000);
    tick(); rtc_rst_n = 1; repeat (3) tick();
    pulse(4'h5); rd(v); chk("R9 alive after", v, ex(4'h5));

    finish_run();
  end
endmodule